// File: doc/BRIEF.md
# MDIO Management Frame Slave Decoder

This block is the target side of a two-wire station-management link. It samples a software-driven clock line and a bidirectional data line with the system clock. It then follows each management frame through its fields in order: a run of idle ones, the start pattern, a two-bit opcode, a five-bit PHY address, a five-bit register address, the two-bit bus hand-over gap and sixteen data bits. When the frame carries this device's address, a read fetches one word from an attached register port and shifts it back out on the data line. A write gathers sixteen bits and hands them to the register port after the last one arrives.

The data line is presented as a split output value and output enable, so that a pad cell or an on-chip bus model can resolve it. When the target is not driving, the output value rests high, so a line with a pull-up reads as ones. A read to any other PHY address is never driven, and the requester therefore reads 0xFFFF. A five-bit strap input sets the device's PHY address. Boards normally tie it to 1.

Top module: `mgmt_frame_slave`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mdio_pin_oe` is 0, `mdio_pin_out` is 1 and the strobes `reg_rd_en`, `reg_wr_en` and `start_warn` are 0.
- R2: A frame is recognised only when the line has carried at least 32 consecutive ones, sampled on clock-line rising edges, before a sampled zero. That zero is taken as the first start bit. A zero that comes earlier clears the run and starts no frame.
- R3: The second start bit is expected to be 1. If it is 0, `start_warn` pulses for one cycle and the frame is still decoded and acted upon.
- R4: For opcode 2'b10 (read) to the strapped address, `reg_rd_en` pulses once with `reg_addr` holding the register field. `mdio_pin_oe` rises after the second hand-over bit. On each following clock-line low phase, `mdio_pin_out` presents the next bit of `reg_rd_data`, MSB first, for 16 bits.
- R5: For opcode 2'b01 (write) to the strapped address, the 16 data bits are sampled MSB first on rising edges. After the 16th bit, a single one-cycle `reg_wr_en` pulse presents the word on `reg_wr_data` and the register field on `reg_addr`.
- R6: A read to any PHY address other than the strap leaves `mdio_pin_oe` at 0, `mdio_pin_out` at 1 and `reg_rd_en` at 0, so a pulled-up line reads 0xFFFF.
- R7: A write to any PHY address other than the strap produces no `reg_wr_en`.
- R8: After the 16th data bit, the decoder returns to idle-preamble search and drops `mdio_pin_oe`. A following frame with exactly 32 preamble ones is decoded.
- R9: Opcodes 2'b00 and 2'b11 produce neither strobe and no drive.
- R10: The address compared is the live `phy_addr_strap` value. Changing the strap moves the device to the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc_pin | input | 1 | Management clock line, asynchronous |
| mdio_pin_in | input | 1 | Management data line as seen at the pad, asynchronous |
| phy_addr_strap | input | 5 | This device's PHY address |
| mdio_pin_out | output | 1 | Value driven onto the data line |
| mdio_pin_oe | output | 1 | Drive enable for the data line |
| reg_addr | output | 5 | Register field of the current frame |
| reg_rd_en | output | 1 | One-cycle read strobe; `reg_rd_data` is taken in that cycle |
| reg_rd_data | input | 16 | Word returned by the register port |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 16 | Word to be written |
| start_warn | output | 1 | One-cycle pulse on a malformed second start bit |

## Verification
The 16th data rising edge does three things in the same cycle. It commits a write or ends a read drive, it drops the output enable, and it clears the preamble counter for the next frame. Frames are therefore sent back to back, each with exactly the minimum 32-bit preamble. Each one must both finish its own action and let the next frame decode. The bench judges this from the write strobe count and content, from the output enable being low between frames, and from the read bits of the following frame.

// File: rtl/mgmt_frame_pkg.sv
// Package: shared types for the management frame slave.
// Holds the frame field state encoding and the opcode values.
package mgmt_frame_pkg;
    typedef enum logic [2:0] {
        ST_PRE,
        ST_START,
        ST_OPC,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } frame_st_t;

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;
endpackage

// File: rtl/mgmt_edge_sync.sv
// Module: mgmt_edge_sync
// Brings W asynchronous lines into the clk domain through two flops each.
// A third flop gives single-cycle rise and fall flags.
// Assumes: inputs stay stable for several clk periods between changes.
module mgmt_edge_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1, s2, s3;
        // Double-flop synchroniser plus history flop; lines idle high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
                s3 <= 1'b1;
            end else begin
                s1 <= async_in[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign sync_out[g] = s2;
        assign rise[g]     = s2 & ~s3;
        assign fall[g]     = ~s2 & s3;
    end
endmodule

// File: rtl/mgmt_frame_fsm.sv
// Module: mgmt_frame_fsm
// Walks the fields of a management frame on clock-line rising edges.
// It issues the read strobe at the end of the hand-over gap and the write
// commit after the last data bit.
// Assumes: mdc_rise is a one-cycle flag and mdio_bit is the synchronised data.
module mgmt_frame_fsm
    import mgmt_frame_pkg::*;
#(
    parameter int PRE_MIN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_rise,
    input  logic              mdio_bit,
    input  logic [ADDR_W-1:0] phy_strap,
    output frame_st_t         st_o,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              warn,
    output logic              frame_end
);
    localparam int PRE_W = $clog2(PRE_MIN + 1);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PRE_MIN);

    frame_st_t         st_q;
    logic [PRE_W-1:0]  pre_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        opc_q;
    logic [ADDR_W-1:0] phy_q;
    logic [DATA_W-1:0] wsh;
    logic              addr_hit;

    assign addr_hit = (phy_q == phy_strap);
    assign st_o     = st_q;

    // Field sequencer: shifts each field MSB first and issues the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_PRE;
            pre_cnt   <= '0;
            bit_cnt   <= '0;
            opc_q     <= '0;
            phy_q     <= '0;
            reg_addr  <= '0;
            wsh       <= '0;
            rd_en     <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            warn      <= 1'b0;
            frame_end <= 1'b0;
        end else begin
            rd_en     <= 1'b0;
            wr_en     <= 1'b0;
            warn      <= 1'b0;
            frame_end <= 1'b0;
            if (mdc_rise) begin
                unique case (st_q)
                    ST_PRE: begin
                        if (!mdio_bit && pre_cnt == PRE_FULL) begin
                            st_q    <= ST_START;
                            pre_cnt <= '0;
                        end else if (!mdio_bit) begin
                            pre_cnt <= '0;
                        end else if (pre_cnt != PRE_FULL) begin
                            pre_cnt <= pre_cnt + 1'b1;
                        end
                    end
                    ST_START: begin
                        warn    <= ~mdio_bit;
                        st_q    <= ST_OPC;
                        bit_cnt <= '0;
                    end
                    ST_OPC: begin
                        opc_q <= {opc_q[0], mdio_bit};
                        if (bit_cnt == CNT_W'(1)) begin
                            st_q    <= ST_PHY;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_PHY: begin
                        phy_q <= {phy_q[ADDR_W-2:0], mdio_bit};
                        if (bit_cnt == CNT_W'(ADDR_W - 1)) begin
                            st_q    <= ST_REG;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_REG: begin
                        reg_addr <= {reg_addr[ADDR_W-2:0], mdio_bit};
                        if (bit_cnt == CNT_W'(ADDR_W - 1)) begin
                            st_q    <= ST_TA;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_TA: begin
                        if (bit_cnt == CNT_W'(1)) begin
                            st_q    <= ST_DATA;
                            bit_cnt <= '0;
                            wsh     <= '0;
                            rd_en   <= (opc_q == OPC_RD) && addr_hit;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        wsh <= {wsh[DATA_W-2:0], mdio_bit};
                        if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                            st_q      <= ST_PRE;
                            bit_cnt   <= '0;
                            pre_cnt   <= '0;
                            frame_end <= 1'b1;
                            if (opc_q == OPC_WR && addr_hit) begin
                                wr_en   <= 1'b1;
                                wr_data <= {wsh[DATA_W-2:0], mdio_bit};
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: st_q <= ST_PRE;
                endcase
            end
        end
    end

    // R7
    wr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr_hit && opc_q == OPC_WR && st_q == ST_PRE));

    // R2
    short_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRE && mdc_rise && !mdio_bit && pre_cnt != PRE_FULL)
        |=> (st_q == ST_PRE));

    // R9
    rd_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (opc_q == OPC_RD && st_q == ST_DATA));
endmodule

// File: rtl/mgmt_read_shifter.sv
// Module: mgmt_read_shifter
// Holds the read word and drives it MSB first, one bit per clock-line
// falling edge.
// Assumes: load and release never coincide with a falling-edge flag.
module mgmt_read_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic              mdc_fall,
    input  logic              release_i,
    output logic              out,
    output logic              oe
);
    logic [DATA_W-1:0] sh;

    // Output driver: turns on at load, steps on low phases, parks high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            out <= 1'b1;
            oe  <= 1'b0;
        end else if (load) begin
            sh  <= word;
            out <= 1'b0;
            oe  <= 1'b1;
        end else if (oe && release_i) begin
            out <= 1'b1;
            oe  <= 1'b0;
        end else if (oe && mdc_fall) begin
            out <= sh[DATA_W-1];
            sh  <= {sh[DATA_W-2:0], 1'b0};
        end
    end

    // R6
    park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> out);

    // R4
    load_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> oe);
endmodule

// File: rtl/mgmt_frame_slave.sv
// Module: mgmt_frame_slave (top)
// The target side of the management link. It synchronises both lines,
// decodes frames and drives read data back.
// Assumes: reg_rd_data is valid combinationally from reg_addr while
// reg_rd_en is high.
module mgmt_frame_slave
    import mgmt_frame_pkg::*;
#(
    parameter int PRE_MIN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_pin,
    input  logic              mdio_pin_in,
    input  logic [ADDR_W-1:0] phy_addr_strap,
    output logic              mdio_pin_out,
    output logic              mdio_pin_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              start_warn
);
    logic [1:0] s_lvl, s_rise, s_fall;
    frame_st_t  st;
    logic       frame_end;

    mgmt_edge_sync #(.W(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({mdio_pin_in, mdc_pin}),
        .sync_out (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    mgmt_frame_fsm #(
        .PRE_MIN (PRE_MIN),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc_rise  (s_rise[0]),
        .mdio_bit  (s_lvl[1]),
        .phy_strap (phy_addr_strap),
        .st_o      (st),
        .reg_addr  (reg_addr),
        .rd_en     (reg_rd_en),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .warn      (start_warn),
        .frame_end (frame_end)
    );

    mgmt_read_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (reg_rd_en),
        .word      (reg_rd_data),
        .mdc_fall  (s_fall[0]),
        .release_i (frame_end),
        .out       (mdio_pin_out),
        .oe        (mdio_pin_oe)
    );

    // R8
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_pin_oe |-> (st == ST_DATA || frame_end));

    // R8
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_pin_oe) |-> (st == ST_PRE));

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R3
    warn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_warn |-> (st == ST_OPC));
endmodule

// File: tb/test_mgmt_frame_slave.sv
module test_mgmt_frame_slave;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mdc_pin, mdio_pin_in;
    logic [4:0]  phy_addr_strap;
    logic        mdio_pin_out, mdio_pin_oe;
    logic [4:0]  reg_addr;
    logic        reg_rd_en, reg_wr_en, start_warn;
    logic [15:0] reg_rd_data, reg_wr_data;

    always #10 clk = ~clk;

    // Attached register port model: word depends on the register field.
    assign reg_rd_data = {~reg_addr, 6'b101101, reg_addr};

    mgmt_frame_slave i_mgmt_frame_slave (
        .clk            (clk),
        .rst_n          (rst_n),
        .mdc_pin        (mdc_pin),
        .mdio_pin_in    (mdio_pin_in),
        .phy_addr_strap (phy_addr_strap),
        .mdio_pin_out   (mdio_pin_out),
        .mdio_pin_oe    (mdio_pin_oe),
        .reg_addr       (reg_addr),
        .reg_rd_en      (reg_rd_en),
        .reg_rd_data    (reg_rd_data),
        .reg_wr_en      (reg_wr_en),
        .reg_wr_data    (reg_wr_data),
        .start_warn     (start_warn)
    );

    int checks = 0, fails = 0;
    int wr_cnt = 0, rd_cnt = 0, warn_cnt = 0;
    logic [4:0]  last_wa, last_ra;
    logic [15:0] last_wd;

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            wr_cnt++; last_wa = reg_addr; last_wd = reg_wr_data;
        end
        if (rst_n && reg_rd_en) begin
            rd_cnt++; last_ra = reg_addr;
        end
        if (rst_n && start_warn) warn_cnt++;
    end

    function automatic logic [15:0] model_word(input logic [4:0] a);
        return {~a, 6'b101101, a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, output logic so, output logic soe);
        @(negedge clk);
        mdc_pin = 1'b0; mdio_pin_in = b;
        repeat (H) @(negedge clk);
        so = mdio_pin_out; soe = mdio_pin_oe;
        mdc_pin = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic run_frame(input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] wd,
                             input int pre, input logic st2,
                             output logic [15:0] line, output bit any_oe);
        logic so, soe;
        any_oe = 1'b0;
        for (int i = 0; i < pre; i++) drive_bit(1'b1, so, soe);
        drive_bit(1'b0, so, soe);
        drive_bit(st2, so, soe);
        for (int i = 1; i >= 0; i--) drive_bit(op[i], so, soe);
        for (int i = 4; i >= 0; i--) drive_bit(phy[i], so, soe);
        for (int i = 4; i >= 0; i--) drive_bit(ra[i], so, soe);
        drive_bit(1'b1, so, soe);
        drive_bit(op == 2'b01 ? 1'b0 : 1'b1, so, soe);
        for (int i = 15; i >= 0; i--) begin
            drive_bit(op == 2'b01 ? wd[i] : 1'b1, so, soe);
            line[i] = soe ? so : 1'b1;
            if (soe) any_oe = 1'b1;
        end
        repeat (4) @(negedge clk);
    endtask

    // {op, phy, reg, data, pad}
    localparam logic [31:0] VEC [0:7] = '{
        {2'b10, 5'd1, 5'd3,  16'h0000, 4'h0},
        {2'b01, 5'd1, 5'd9,  16'hA5C3, 4'h0},
        {2'b10, 5'd2, 5'd3,  16'h0000, 4'h0},
        {2'b01, 5'd5, 5'd1,  16'h1234, 4'h0},
        {2'b00, 5'd1, 5'd6,  16'h5555, 4'h0},
        {2'b11, 5'd1, 5'd6,  16'hAAAA, 4'h0},
        {2'b10, 5'd1, 5'd31, 16'h0000, 4'h0},
        {2'b01, 5'd1, 5'd0,  16'h8001, 4'h0}
    };

    task automatic judge(input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd,
                         input int wr0, input int rd0,
                         input logic [15:0] line, input bit any_oe);
        bit hit = (phy == phy_addr_strap);
        if (op == 2'b10 && hit) begin
            check(rd_cnt == rd0 + 1, "R4", "read strobes", rd_cnt - rd0, 1);
            check(last_ra == ra, "R4", "read reg addr", last_ra, ra);
            check(line == model_word(ra), "R4", "read bits", line, model_word(ra));
        end else if (op == 2'b10) begin
            check(!any_oe && rd_cnt == rd0, "R6", "absent read drive/strobe",
                  {any_oe, 8'(rd_cnt - rd0)}, 0);
            check(line == 16'hFFFF, "R6", "absent read line", line, 16'hFFFF);
        end else if (op == 2'b01 && hit) begin
            check(wr_cnt == wr0 + 1, "R5", "write strobes", wr_cnt - wr0, 1);
            check(last_wa == ra && last_wd == wd, "R5", "write addr/data",
                  {last_wa, last_wd}, {ra, wd});
        end else if (op == 2'b01) begin
            check(wr_cnt == wr0, "R7", "absent write strobes", wr_cnt - wr0, 0);
        end else begin
            check(!any_oe && wr_cnt == wr0 && rd_cnt == rd0, "R9",
                  "reserved opcode activity", {any_oe, 8'(wr_cnt - wr0), 8'(rd_cnt - rd0)}, 0);
        end
        check(mdio_pin_oe == 1'b0, "R8", "drive released after frame", mdio_pin_oe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] line;
        bit any_oe;
        int wr0, rd0, w0;
        rst_n = 1'b0; mdc_pin = 1'b1; mdio_pin_in = 1'b1; phy_addr_strap = 5'd1;
        repeat (5) @(negedge clk);
        // R1
        check(!mdio_pin_oe && mdio_pin_out && !reg_rd_en && !reg_wr_en && !start_warn,
              "R1", "reset outputs",
              {mdio_pin_oe, mdio_pin_out, reg_rd_en, reg_wr_en, start_warn}, 5'b01000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Back-to-back table frames, each with the minimum 32-bit preamble (R2, R8).
        for (int v = 0; v < 8; v++) begin
            wr0 = wr_cnt; rd0 = rd_cnt;
            run_frame(VEC[v][31:30], VEC[v][29:25], VEC[v][24:20], VEC[v][19:4],
                      32, 1'b1, line, any_oe);
            judge(VEC[v][31:30], VEC[v][29:25], VEC[v][24:20], VEC[v][19:4],
                  wr0, rd0, line, any_oe);
        end
        // R3: clean start patterns raised no warning
        check(warn_cnt == 0, "R3", "no warn on clean frames", warn_cnt, 0);

        // R2: only 10 preamble ones, so the frame must be ignored
        wr0 = wr_cnt;
        run_frame(2'b01, 5'd1, 5'd31, 16'hFFFF, 10, 1'b1, line, any_oe);
        check(wr_cnt == wr0 && !any_oe, "R2", "short preamble ignored", wr_cnt - wr0, 0);

        // R2: full preamble right after recovers decoding
        wr0 = wr_cnt; rd0 = rd_cnt;
        run_frame(2'b01, 5'd1, 5'd12, 16'h0F0F, 32, 1'b1, line, any_oe);
        judge(2'b01, 5'd1, 5'd12, 16'h0F0F, wr0, rd0, line, any_oe);

        // R3: a bad second start bit warns but the write still commits
        wr0 = wr_cnt; rd0 = rd_cnt; w0 = warn_cnt;
        run_frame(2'b01, 5'd1, 5'd17, 16'hBEEF, 32, 1'b0, line, any_oe);
        check(warn_cnt == w0 + 1, "R3", "start warning pulses", warn_cnt - w0, 1);
        judge(2'b01, 5'd1, 5'd17, 16'hBEEF, wr0, rd0, line, any_oe);

        // R10: move the strap to 7
        phy_addr_strap = 5'd7;
        wr0 = wr_cnt; rd0 = rd_cnt;
        run_frame(2'b10, 5'd7, 5'd4, 16'h0, 32, 1'b1, line, any_oe);
        check(line == model_word(5'd4) && rd_cnt == rd0 + 1, "R10", "read at new strap",
              line, model_word(5'd4));
        wr0 = wr_cnt; rd0 = rd_cnt;
        run_frame(2'b10, 5'd1, 5'd4, 16'h0, 32, 1'b1, line, any_oe);
        check(!any_oe && rd_cnt == rd0 && line == 16'hFFFF, "R10", "old address now absent",
              line, 16'hFFFF);
        wr0 = wr_cnt; rd0 = rd_cnt;
        run_frame(2'b01, 5'd7, 5'd2, 16'h7E81, 32, 1'b1, line, any_oe);
        check(wr_cnt == wr0 + 1 && last_wd == 16'h7E81, "R10", "write at new strap",
              last_wd, 16'h7E81);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule